// File: doc/BRIEF.md
# Four-Bank Interleaved Block Read Controller

This controller fetches one cache block of four words from a main memory that is split into four word-interleaved banks. Word w of block B is held in bank w at row B. When a block address is accepted, every bank latches the same row and starts its access in the same cycle. A fixed access latency, set by a parameter, is counted down once for all banks. The four words then go back to the requester over one word-wide path, one word per cycle, bank 0 first.

The requester uses a valid/ready request port that carries the block address. It receives a response stream made of a data word, the word's index in the block, a valid flag and a last flag. A block occupies the controller for one address cycle, ACC_LAT access cycles and four transfer cycles. With the default latency of 10 that is 15 cycles. A memory four words wide would need 1 + 10 + 1 cycles, and one sequential bank would need 1 + 4 × 11. Bank contents are a fixed pattern that is loaded at reset, because writes are outside this block's scope.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1 and rsp_valid is 0.
- R2: A request is accepted at a clock edge where req_valid and req_ready are both 1. From the next cycle, req_ready stays 0 until the cycle after the last word, when it returns to 1.
- R3: A request raised while req_ready is 0 is ignored. It changes neither the words returned for the block in flight nor the state after that block: req_ready stays 1 and rsp_valid stays 0.
- R4: Take the cycle that begins at the accepting edge as cycle 0. Word i (0..3) is presented in cycle ACC_LAT+1+i, and req_ready is 1 again in cycle ACC_LAT+5.
- R5: The word with index i of block address A equals bank i's content at row A. The content of word address W = 4·A + i (taken as 16 bits) is {W XOR 16'hC3A5, NOT W}, with the XOR term in bits 31:16.
- R6: Within one block, rsp_idx runs 0, 1, 2, 3 on consecutive cycles, with rsp_valid held at 1 for all four.
- R7: rsp_last is 1 only with the word whose index is 3.
- R8: rsp_valid is 0 and rsp_data is zero in every cycle outside the four transfer cycles.
- R9: The timing in R4 holds for any ACC_LAT of 1 or more, not only the default of 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Block read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W (6) | Block address, which is also the bank row |
| rsp_valid | output | 1 | Response word present |
| rsp_idx | output | 2 | Word index within the block, which is also the bank number |
| rsp_data | output | WORD_W (32) | Response word |
| rsp_last | output | 1 | Marks the final word of the block |

## Verification
Each block is timed from its accepting edge. Outputs are sampled at the falling edge of every cycle after that edge. rsp_valid must be 0 through cycle ACC_LAT, word i must appear in cycle ACC_LAT+1+i, and req_ready must return in cycle ACC_LAT+5, so an early or late word by a single cycle fails a check. The bench runs a second instance with ACC_LAT = 3 through the same cycle-indexed checks to cover R9. Requests that arrive while the controller is busy are injected partway through the access wait. After such a block, three idle cycles confirm that no block was started.

// File: rtl/ilv_pkg.sv
// Package: shared state type and the fixed bank fill pattern.
// Assumes word addresses fit in 16 bits.
package ilv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACCESS,
        ST_XFER
    } ilv_state_e;

    // Fill pattern for the word at a 16-bit word address.
    function automatic logic [31:0] fill_word(input logic [15:0] waddr);
        return {waddr ^ 16'hC3A5, ~waddr};
    endfunction

endpackage

// File: rtl/ilv_bank.sv
// One memory bank: rows are loaded with the fill pattern at reset.
// The row is latched when an access starts and the word is registered on capture.
// Assumes capture comes at least one cycle after start.
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int ROW_W   = 6,
    parameter int NBANK   = 4,
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  row,
    input  logic              capture,
    output logic [WORD_W-1:0] data
);
    localparam int ROWS = 1 << ROW_W;

    logic [WORD_W-1:0] mem [ROWS];
    logic [ROW_W-1:0]  row_q;

    // Storage fill on reset, row latch on start, word capture at end of access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= WORD_W'(fill_word(16'(r * NBANK + BANK_ID)));
            end
            row_q <= '0;
            data  <= '0;
        end else begin
            if (start) begin
                row_q <= row;
            end
            if (capture) begin
                data <= mem[row_q];
            end
        end
    end

    // R5: the returned word only changes on capture.
    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(data));

endmodule

// File: rtl/ilv_seq.sv
// Sequencer: accepts a request, spends one address cycle, counts the
// access latency once for all banks, then steps the word index over the
// transfer cycles. Assumes ACC_LAT >= 1.
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int ACC_LAT = 10,
    parameter int NBANK   = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    output logic             bank_start,
    output logic             bank_capture,
    output logic             rsp_valid,
    output logic [IDX_W-1:0] rsp_idx,
    output logic             rsp_last
);
    localparam int CNT_W = (ACC_LAT < 2) ? 1 : $clog2(ACC_LAT);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(ACC_LAT - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NBANK - 1);

    ilv_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;

    // State, latency counter and word index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    state <= ST_ACCESS;
                    cnt   <= '0;
                end
                ST_ACCESS: begin
                    if (cnt == CNT_END) begin
                        state <= ST_XFER;
                        idx   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (idx == IDX_END) begin
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state.
    always_comb begin
        req_ready    = (state == ST_IDLE);
        bank_start   = (state == ST_IDLE) && req_valid;
        bank_capture = (state == ST_ACCESS) && (cnt == CNT_END);
        rsp_valid    = (state == ST_XFER);
        rsp_idx      = (state == ST_XFER) ? idx : '0;
        rsp_last     = (state == ST_XFER) && (idx == IDX_END);
    end

    // R2: an accepted request blocks further ones in the next cycle.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R2: ready returns right after the last word.
    a_r2_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> req_ready);
    // R6: words follow on consecutive cycles with rising index.
    a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> (rsp_valid && rsp_idx == $past(rsp_idx) + 1'b1));
    // R6: a block starts at index 0.
    a_r6_first_idx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (rsp_idx == '0));
    // R7: the last flag goes only with the final index.
    a_r7_last_idx: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> (rsp_valid && rsp_idx == IDX_END));
    // R8: no response while a request can be accepted.
    a_r8_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

// File: rtl/ilv_ret_mux.sv
// Return path: selects the bank word for the current index onto the one
// word-wide response bus and drives zero outside transfer cycles.
module ilv_ret_mux #(
    parameter int WORD_W = 32,
    parameter int NBANK  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [WORD_W-1:0] words [NBANK],
    input  logic              sel_valid,
    input  logic [IDX_W-1:0]  sel,
    output logic [WORD_W-1:0] data
);
    // Gated word select.
    always_comb begin
        data = '0;
        if (sel_valid) begin
            data = words[sel];
        end
    end

    // R8: the bus is zero outside transfers.
    a_r8_zero_bus: assert final (sel_valid || data == '0);

endmodule

// File: rtl/ilv_mem_ctrl.sv
// Top: four word-interleaved banks that share one row address and one
// latency count, with a serial word-wide return path.
// Assumes ACC_LAT >= 1 and NBANK a power of two.
module ilv_mem_ctrl #(
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 6,
    parameter int NBANK   = 4,
    parameter int ACC_LAT = 10,
    localparam int IDX_W  = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_last
);
    logic              bank_start;
    logic              bank_capture;
    logic [WORD_W-1:0] bank_words [NBANK];

    ilv_seq #(
        .ACC_LAT (ACC_LAT),
        .NBANK   (NBANK),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .bank_start   (bank_start),
        .bank_capture (bank_capture),
        .rsp_valid    (rsp_valid),
        .rsp_idx      (rsp_idx),
        .rsp_last     (rsp_last)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ilv_bank #(
            .WORD_W  (WORD_W),
            .ROW_W   (ADDR_W),
            .NBANK   (NBANK),
            .BANK_ID (b)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (bank_start),
            .row     (req_addr),
            .capture (bank_capture),
            .data    (bank_words[b])
        );
    end

    ilv_ret_mux #(
        .WORD_W (WORD_W),
        .NBANK  (NBANK),
        .IDX_W  (IDX_W)
    ) u_mux (
        .words     (bank_words),
        .sel_valid (rsp_valid),
        .sel       (rsp_idx),
        .data      (rsp_data)
    );

endmodule

// File: tb/ilv_mem_ctrl_test.sv
`timescale 1ns/1ps
module ilv_mem_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_a [2];
    logic [5:0]  req_addr_a  [2];
    logic        req_ready_a [2];
    logic        rsp_valid_a [2];
    logic [1:0]  rsp_idx_a   [2];
    logic [31:0] rsp_data_a  [2];
    logic        rsp_last_a  [2];
    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ilv_mem_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_a[0]), .req_ready(req_ready_a[0]),
        .req_addr(req_addr_a[0]), .rsp_valid(rsp_valid_a[0]), .rsp_idx(rsp_idx_a[0]),
        .rsp_data(rsp_data_a[0]), .rsp_last(rsp_last_a[0]));

    ilv_mem_ctrl #(.ACC_LAT(3)) uut_fast (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_a[1]), .req_ready(req_ready_a[1]),
        .req_addr(req_addr_a[1]), .rsp_valid(rsp_valid_a[1]), .rsp_idx(rsp_idx_a[1]),
        .rsp_data(rsp_data_a[1]), .rsp_last(rsp_last_a[1]));

    function automatic int lat_of(int u);
        return (u == 0) ? 10 : 3;
    endfunction

    // Expected word per R5.
    function automatic logic [31:0] exp_word(logic [5:0] a, int i);
        logic [15:0] w;
        w = 16'(a) * 16'd4 + 16'(i);
        return {w ^ 16'hC3A5, ~w};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Runs one block on unit u; when poke is set, a busy-time request is raised (R3).
    // Entered and left just after a falling edge.
    task automatic run_block(int u, logic [5:0] a, bit poke);
        int L;
        L = lat_of(u);
        while (!req_ready_a[u]) @(negedge clk);
        req_valid_a[u] = 1'b1;
        req_addr_a[u]  = a;
        @(negedge clk);
        req_valid_a[u] = 1'b0;
        req_addr_a[u]  = 6'h00;
        for (int m = 0; m <= L + 5; m++) begin
            bit xfer;
            int i;
            xfer = (m >= L + 1) && (m <= L + 4);
            i    = m - (L + 1);
            chk(req_ready_a[u] == (m == L + 5), "R2/R4 req_ready", 32'(req_ready_a[u]), 32'(m == L + 5));
            chk(rsp_valid_a[u] == xfer, (u == 0) ? "R4/R8 rsp_valid" : "R9 rsp_valid",
                32'(rsp_valid_a[u]), 32'(xfer));
            if (xfer) begin
                chk(rsp_idx_a[u] == 2'(i), "R6 rsp_idx", 32'(rsp_idx_a[u]), 32'(i));
                chk(rsp_data_a[u] == exp_word(a, i), "R5 rsp_data", rsp_data_a[u], exp_word(a, i));
                chk(rsp_last_a[u] == (i == 3), "R7 rsp_last", 32'(rsp_last_a[u]), 32'(i == 3));
            end else begin
                chk(rsp_data_a[u] == 32'h0 && !rsp_last_a[u], "R8 idle bus", rsp_data_a[u], 32'h0);
            end
            if (poke && m == 2) begin
                req_valid_a[u] = 1'b1;
                req_addr_a[u]  = ~a;
            end
            if (poke && m == 4) begin
                req_valid_a[u] = 1'b0;
                req_addr_a[u]  = 6'h00;
            end
            if (m < L + 5) @(negedge clk);
        end
    endtask

    // Idle observation with no request (R3).
    task automatic idle_check(int u, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(req_ready_a[u] && !rsp_valid_a[u], "R3 no stray block",
                {30'd0, req_ready_a[u], rsp_valid_a[u]}, 32'h2);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int u = 0; u < 2; u++) begin
            req_valid_a[u] = 1'b0;
            req_addr_a[u]  = 6'h00;
        end
        repeat (3) @(negedge clk);
        chk(req_ready_a[0] && !rsp_valid_a[0], "R1 reset state", {30'd0, req_ready_a[0], rsp_valid_a[0]}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready_a[0] && !rsp_valid_a[0], "R1 after reset", {30'd0, req_ready_a[0], rsp_valid_a[0]}, 32'h2);
        chk(req_ready_a[1] && !rsp_valid_a[1], "R1 after reset fast", {30'd0, req_ready_a[1], rsp_valid_a[1]}, 32'h2);
        // Directed corners: lowest and highest address, back to back.
        run_block(0, 6'h00, 1'b0);
        run_block(0, 6'h3F, 1'b0);
        // Busy-time request is ignored.
        run_block(0, 6'h15, 1'b1);
        idle_check(0, 3);
        // R9: shorter latency.
        run_block(1, 6'h2A, 1'b0);
        run_block(1, 6'h01, 1'b1);
        idle_check(1, 3);
        // Random addresses and gaps.
        for (int n = 0; n < 24; n++) begin
            int u;
            u = n % 2;
            repeat ($urandom_range(0, 3)) @(negedge clk);
            run_block(u, 6'($urandom_range(0, 63)), 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule